// File: doc/BRIEF.md
# LCD Scan Line and Mapping Sequencer

This block drives the row scan of a dot-matrix display with 32 graphic rows, one icon row and 120 columns. On each display-clock tick it advances a slot counter. When a slot ends it moves to the next common. For the active common it computes the display RAM row to fetch and presents that row on the segment outputs, in normal or reversed column order. It also toggles a frame polarity signal once per frame.

Vertical scroll, row reversal, column reversal, the multiplex selection (16, 32 or 33 commons), the icon-only mode and the slow/fast frame length all come in on plain configuration inputs. The sequencer copies them into a shadow set at the start of every frame. The RAM is read combinationally: the block drives `ram_row` and expects that row's bits on `ram_data` in the same cycle.

The controller has three states:
- `ST_OFF`: outputs are blank.
- `ST_ROWS`: scanning graphic commons.
- `ST_ICON`: the icon common is selected.

Its transitions are:
- **start** (`ST_OFF` to `ST_ROWS`, or to `ST_ICON` in icon-only mode): a tick while the display is enabled.
- **advance** (within `ST_ROWS`): the next common.
- **to_icon** (`ST_ROWS` to `ST_ICON`): taken after the last graphic common in 33-common mode.
- **frame_wrap**: from the last slot of a frame to the first common of the next frame, reloading the shadow configuration and toggling polarity.
- **stop** (any state to `ST_OFF`): the display enable is low.

Top module: `lcd_scan_seq`

## Requirements
- R1: After reset, and while the display enable is low, `com_sel` is all zero, `seg_out` is all zero and `frame_pol` is 0.
- R2: For a graphic common k (0 to 31) without row reversal, the fetched RAM row is (k + scroll) mod 32. For example, with scroll = 1, common 31 shows row 0.
- R3: With row reversal on, the line index is first mirrored to 31 - k, and the scroll is then added modulo 32.
- R4: With column reversal on, on a graphic common, RAM column c appears on segment 119 - c. With it off, column c appears on segment c.
- R5: Common 32 always shows RAM row 32 with columns in normal order, whatever the scroll, row reversal and column reversal settings.
- R6: `duty_sel` encoding: 00 scans commons 0..31, 01 scans commons 0..15 only, and 10 or 11 scans commons 0..32. Commons are scanned in ascending order.
- R7: The frame length is 576 ticks when `fast_clk` = 0 and 768 ticks when it is 1. Each common is held for floor(frame / number of commons) ticks, where the icon-only mode counts as one common.
- R8: `frame_pol` toggles when the scan wraps from the last slot of a frame to the first common of the next frame.
- R9: With `icon_only` = 1, only common 32 is selected, for a whole frame per frame.
- R10: When the enable goes low, all outputs are zero after the next clock edge. A later enable restarts the scan at the first common of a new frame, with polarity 0, on the first tick.
- R11: Configuration changes made mid-frame take effect only at the next frame boundary.
- R12: At most one common is selected at a time, and the scan advances only on cycles with `tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Display-clock enable, one pulse per display clock |
| disp_on | input | 1 | Display enable |
| fast_clk | input | 1 | 1 selects the 768-tick frame, 0 the 576-tick frame |
| duty_sel | input | 2 | Multiplex select (00 = 32, 01 = 16, 1x = 33) |
| icon_only | input | 1 | Icon-only scan mode |
| row_rev | input | 1 | Row reversal for graphic commons |
| col_rev | input | 1 | Column reversal for graphic commons |
| scroll | input | 5 | Vertical scroll amount |
| ram_row | output | 6 | RAM row address being fetched |
| ram_data | input | 120 | Bits of the addressed RAM row |
| com_sel | output | 33 | One-hot common select |
| seg_out | output | 120 | Segment data for the active common |
| frame_pol | output | 1 | Frame polarity |

## Verification
The assertions check the following on every cycle:
- the common select is never more than one-hot;
- the common select and the polarity move only on a tick or on a disable;
- a low enable blanks every output after one edge;
- whenever common 32 is active, it fetches row 32 and passes that row through unreversed.

Only the bench scenarios can show the rest:
- the scroll and mirror arithmetic on graphic commons;
- the exact slot and frame lengths for each multiplex and clock setting;
- the 16-common and 33-common wrap points;
- that a mid-frame configuration change waits for the next frame boundary.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;
    localparam int unsigned LCD_ROWS = 32;
    localparam int unsigned SCROLL_W = $clog2(LCD_ROWS);

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ROWS = 2'd1,
        ST_ICON = 2'd2
    } scan_state_t;

    typedef struct packed {
        logic                fast;
        logic [1:0]          duty;
        logic                icon;
        logic                rrev;
        logic                crev;
        logic [SCROLL_W-1:0] scroll;
    } scan_cfg_t;
endpackage

// File: rtl/lcd_scan_slot.sv
`timescale 1ns/1ps
module lcd_scan_slot #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] slot_len,
    output logic             slot_last
);
    logic [CNT_W-1:0] cnt_q;

    assign slot_last = (cnt_q == slot_len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= slot_last ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lcd_scan_rowmap.sv
`timescale 1ns/1ps
module lcd_scan_rowmap #(
    parameter int NROW = 32,
    parameter int SW   = $clog2(NROW),
    parameter int AW   = $clog2(NROW + 1)
) (
    input  logic [AW-1:0] com_idx,
    input  logic          rrev,
    input  logic [SW-1:0] scroll,
    output logic [AW-1:0] row_addr
);
    logic [SW-1:0] line;
    logic [SW-1:0] shifted;

    // Mirror first (31-k equals bitwise inverse for a power-of-two row count), then scroll.
    assign line     = rrev ? ~com_idx[SW-1:0] : com_idx[SW-1:0];
    assign shifted  = line + scroll;
    assign row_addr = (com_idx == AW'(NROW)) ? AW'(NROW) : AW'(shifted);
endmodule

// File: rtl/lcd_scan_colmap.sv
`timescale 1ns/1ps
module lcd_scan_colmap #(
    parameter int NSEG = 120
) (
    input  logic [NSEG-1:0] din,
    input  logic            rev,
    input  logic            blank,
    output logic [NSEG-1:0] dout
);
    for (genvar c = 0; c < NSEG; c++) begin : g_col
        assign dout[c] = !blank && (rev ? din[NSEG-1-c] : din[c]);
    end
endmodule

// File: rtl/lcd_scan_seq.sv
`timescale 1ns/1ps
module lcd_scan_seq
    import lcd_scan_pkg::*;
#(
    parameter int NSEG       = 120,
    parameter int SLOW_FRAME = 576,
    parameter int FAST_FRAME = 768
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          tick,
    input  logic                          disp_on,
    input  logic                          fast_clk,
    input  logic [1:0]                    duty_sel,
    input  logic                          icon_only,
    input  logic                          row_rev,
    input  logic                          col_rev,
    input  logic [SCROLL_W-1:0]           scroll,
    output logic [$clog2(LCD_ROWS+1)-1:0] ram_row,
    input  logic [NSEG-1:0]               ram_data,
    output logic [LCD_ROWS:0]             com_sel,
    output logic [NSEG-1:0]               seg_out,
    output logic                          frame_pol
);
    localparam int NROW   = LCD_ROWS;
    localparam int AW     = $clog2(NROW + 1);
    localparam int MAXF   = (FAST_FRAME > SLOW_FRAME) ? FAST_FRAME : SLOW_FRAME;
    localparam int CNT_W  = $clog2(MAXF + 1);
    localparam int SL_16  = SLOW_FRAME / (NROW / 2);
    localparam int SL_32  = SLOW_FRAME / NROW;
    localparam int SL_33  = SLOW_FRAME / (NROW + 1);
    localparam int FS_16  = FAST_FRAME / (NROW / 2);
    localparam int FS_32  = FAST_FRAME / NROW;
    localparam int FS_33  = FAST_FRAME / (NROW + 1);

    scan_state_t      state_q, state_d;
    logic [AW-1:0]    com_q, com_d;
    logic             pol_q, pol_d;
    scan_cfg_t        cfg_q, cfg_d, cfg_in;
    logic             frame_end;
    logic             slot_last;
    logic [CNT_W-1:0] slot_len;
    logic [AW-1:0]    last_main;
    logic             blank;
    logic             seg_rev;

    always_comb begin
        cfg_in.fast   = fast_clk;
        cfg_in.duty   = duty_sel;
        cfg_in.icon   = icon_only;
        cfg_in.rrev   = row_rev;
        cfg_in.crev   = col_rev;
        cfg_in.scroll = scroll;
    end

    // Slot length from the shadowed configuration.
    always_comb begin
        if (cfg_q.icon) begin
            slot_len = cfg_q.fast ? CNT_W'(FAST_FRAME) : CNT_W'(SLOW_FRAME);
        end else begin
            unique case (cfg_q.duty)
                2'b01:   slot_len = cfg_q.fast ? CNT_W'(FS_16) : CNT_W'(SL_16);
                2'b00:   slot_len = cfg_q.fast ? CNT_W'(FS_32) : CNT_W'(SL_32);
                default: slot_len = cfg_q.fast ? CNT_W'(FS_33) : CNT_W'(SL_33);
            endcase
        end
    end

    assign last_main = (cfg_q.duty == 2'b01) ? AW'(NROW / 2 - 1) : AW'(NROW - 1);

    lcd_scan_slot #(.CNT_W(CNT_W)) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state_q == ST_OFF),
        .tick      (tick),
        .slot_len  (slot_len),
        .slot_last (slot_last)
    );

    // Next-state logic: start, advance, to_icon, frame_wrap, stop.
    always_comb begin
        state_d   = state_q;
        com_d     = com_q;
        pol_d     = pol_q;
        cfg_d     = cfg_q;
        frame_end = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                pol_d = 1'b0;
                com_d = '0;
                if (disp_on && tick) begin
                    cfg_d   = cfg_in;
                    state_d = cfg_in.icon ? ST_ICON : ST_ROWS;
                    com_d   = cfg_in.icon ? AW'(NROW) : '0;
                end
            end
            ST_ROWS: begin
                if (tick && slot_last) begin
                    if (com_q == last_main) begin
                        if (cfg_q.duty[1]) begin
                            state_d = ST_ICON;
                            com_d   = AW'(NROW);
                        end else begin
                            frame_end = 1'b1;
                        end
                    end else begin
                        com_d = com_q + AW'(1);
                    end
                end
            end
            ST_ICON: begin
                if (tick && slot_last) frame_end = 1'b1;
            end
            default: state_d = ST_OFF;
        endcase
        if (frame_end) begin
            cfg_d   = cfg_in;
            pol_d   = ~pol_q;
            state_d = cfg_in.icon ? ST_ICON : ST_ROWS;
            com_d   = cfg_in.icon ? AW'(NROW) : '0;
        end
        if (!disp_on) begin
            state_d = ST_OFF;
            com_d   = '0;
            pol_d   = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            com_q   <= '0;
            pol_q   <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            com_q   <= com_d;
            pol_q   <= pol_d;
            cfg_q   <= cfg_d;
        end
    end

    // Outputs.
    always_comb begin
        com_sel = '0;
        if (state_q != ST_OFF) com_sel[com_q] = 1'b1;
        blank     = (state_q == ST_OFF);
        seg_rev   = cfg_q.crev && (com_q != AW'(NROW));
        frame_pol = pol_q;
    end

    lcd_scan_rowmap #(.NROW(NROW)) u_rowmap (
        .com_idx  (com_q),
        .rrev     (cfg_q.rrev),
        .scroll   (cfg_q.scroll),
        .row_addr (ram_row)
    );

    lcd_scan_colmap #(.NSEG(NSEG)) u_colmap (
        .din   (ram_data),
        .rev   (seg_rev),
        .blank (blank),
        .dout  (seg_out)
    );
endmodule

// File: rtl/lcd_scan_seq_chk.sv
`timescale 1ns/1ps
module lcd_scan_seq_chk #(
    parameter int NSEG = 120,
    parameter int NROW = 32,
    parameter int AW   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            disp_on,
    input logic [AW-1:0]   ram_row,
    input logic [NSEG-1:0] ram_data,
    input logic [NROW:0]   com_sel,
    input logic [NSEG-1:0] seg_out,
    input logic            frame_pol
);
    p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(com_sel));

    p_off_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (com_sel == '0 && seg_out == '0 && !frame_pol));

    p_com_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (com_sel != $past(com_sel)) |-> ($past(tick) || !$past(disp_on)));

    p_pol_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((frame_pol != $past(frame_pol)) && $past(disp_on)) |-> $past(tick));

    p_icon_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        com_sel[NROW] |-> (ram_row == AW'(NROW) && seg_out == ram_data));
endmodule

bind lcd_scan_seq lcd_scan_seq_chk #(.NSEG(NSEG), .NROW(NROW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .disp_on   (disp_on),
    .ram_row   (ram_row),
    .ram_data  (ram_data),
    .com_sel   (com_sel),
    .seg_out   (seg_out),
    .frame_pol (frame_pol)
);

// File: tb/test_lcd_scan_seq.sv
`timescale 1ns/1ps
module test_lcd_scan_seq;
    import lcd_scan_pkg::*;

    localparam int NSEG = 120;
    localparam int NV   = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          disp_on = 1'b0;
    logic          fast_clk = 1'b0;
    logic [1:0]    duty_sel = 2'b00;
    logic          icon_only = 1'b0;
    logic          row_rev = 1'b0;
    logic          col_rev = 1'b0;
    logic [4:0]    scroll = '0;
    logic [5:0]    ram_row;
    logic [NSEG-1:0] ram_data;
    logic [32:0]   com_sel;
    logic [NSEG-1:0] seg_out;
    logic          frame_pol;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    lcd_scan_seq i_lcd_scan_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .disp_on(disp_on),
        .fast_clk(fast_clk), .duty_sel(duty_sel), .icon_only(icon_only),
        .row_rev(row_rev), .col_rev(col_rev), .scroll(scroll),
        .ram_row(ram_row), .ram_data(ram_data), .com_sel(com_sel),
        .seg_out(seg_out), .frame_pol(frame_pol)
    );

    // RAM model: row number in low bits, marker bits at the top.
    function automatic logic [NSEG-1:0] pat(input logic [5:0] r);
        logic [NSEG-1:0] p;
        p = '0;
        p[5:0]      = r;
        p[NSEG-1]   = 1'b1;
        p[NSEG-2]   = ~r[0];
        return p;
    endfunction

    function automatic logic [NSEG-1:0] flip(input logic [NSEG-1:0] d);
        logic [NSEG-1:0] f;
        for (int c = 0; c < NSEG; c++) f[c] = d[NSEG-1-c];
        return f;
    endfunction

    function automatic int slot_of(input bit fast, input logic [1:0] duty, input bit icon);
        int fl, mux;
        fl = fast ? 768 : 576;
        if (icon) mux = 1;
        else if (duty == 2'b01) mux = 16;
        else if (duty == 2'b00) mux = 32;
        else mux = 33;
        return fl / mux;
    endfunction

    function automatic int exp_row(input int k, input bit rr, input int s);
        int l;
        if (k == 32) return 32;
        l = rr ? 31 - k : k;
        return (l + s) % 32;
    endfunction

    function automatic logic [NSEG-1:0] exp_seg(input int k, input bit rr, input bit cr, input int s);
        logic [NSEG-1:0] d;
        d = pat(6'(exp_row(k, rr, s)));
        return (cr && k != 32) ? flip(d) : d;
    endfunction

    assign ram_data = pat(ram_row);

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start_scan();
        disp_on = 1'b0;
        tick    = 1'b1;
        clocks(1);
        disp_on = 1'b1;
        clocks(1);
    endtask

    // {duty[16:15], fast[14], scroll[13:9], rrev[8], crev[7], icon[6], probe[5:0]}
    localparam logic [16:0] VEC [NV] = '{
        {2'b00, 1'b0, 5'd0,  1'b0, 1'b0, 1'b0, 6'd0},
        {2'b00, 1'b1, 5'd1,  1'b0, 1'b0, 1'b0, 6'd31},
        {2'b00, 1'b0, 5'd5,  1'b1, 1'b0, 1'b0, 6'd3},
        {2'b00, 1'b0, 5'd0,  1'b0, 1'b1, 1'b0, 6'd7},
        {2'b01, 1'b1, 5'd0,  1'b0, 1'b0, 1'b0, 6'd15},
        {2'b10, 1'b0, 5'd3,  1'b1, 1'b1, 1'b0, 6'd32},
        {2'b00, 1'b0, 5'd9,  1'b1, 1'b1, 1'b1, 6'd32},
        {2'b10, 1'b1, 5'd31, 1'b0, 1'b0, 1'b0, 6'd10},
        {2'b01, 1'b0, 5'd2,  1'b1, 1'b0, 1'b0, 6'd8},
        {2'b11, 1'b1, 5'd0,  1'b0, 1'b1, 1'b0, 6'd32}
    };

    initial begin
        int len;
        // R1: reset state
        clocks(3);
        rst_n = 1'b1;
        clocks(2);
        check("R1 com after reset", 128'(com_sel), 128'(0));
        check("R1 seg after reset", 128'(seg_out), 128'(0));
        check("R1 pol after reset", 128'(frame_pol), 128'(0));

        // R12: no start without a tick
        disp_on = 1'b1;
        clocks(5);
        check("R12 no tick no start", 128'(com_sel), 128'(0));
        tick = 1'b1;
        clocks(1);
        check("R10 start at common 0", 128'(com_sel), 128'(33'd1));

        // R7: slot boundary, 32 mux slow -> 18 ticks
        clocks(17);
        check("R7 last tick of slot 0", 128'(com_sel), 128'(33'd1));
        clocks(1);
        check("R7 slot 1 begins", 128'(com_sel), 128'(33'd2));

        // R12: hold when tick low
        tick = 1'b0;
        clocks(40);
        check("R12 hold without tick", 128'(com_sel), 128'(33'd2));
        tick = 1'b1;

        // R8: frame boundary
        clocks(32 * 18 - 18 - 1);
        check("R8 last common before wrap", 128'(com_sel), 128'(33'd1 << 31));
        check("R8 pol before wrap", 128'(frame_pol), 128'(0));
        clocks(1);
        check("R8 wrap to common 0", 128'(com_sel), 128'(33'd1));
        check("R8 pol toggled", 128'(frame_pol), 128'(1));

        // R11: mid-frame change waits for the frame boundary
        clocks(5);
        scroll  = 5'd4;
        col_rev = 1'b1;
        clocks(13);
        check("R11 old mapping kept mid-frame", 128'(seg_out), 128'(exp_seg(1, 0, 0, 0)));
        clocks(576 - 18 - 1);
        check("R11 old mapping on last common", 128'(seg_out), 128'(exp_seg(31, 0, 0, 0)));
        clocks(1);
        check("R11 new mapping after boundary", 128'(seg_out), 128'(exp_seg(0, 0, 1, 4)));
        check("R8 pol toggled back", 128'(frame_pol), 128'(0));

        // R6: 16-common wrap
        scroll = '0; col_rev = 1'b0; duty_sel = 2'b01; fast_clk = 1'b1;
        start_scan();
        clocks(16 * 48 - 1);
        check("R6 16 mux last common", 128'(com_sel), 128'(33'd1 << 15));
        clocks(1);
        check("R6 16 mux wraps to 0", 128'(com_sel), 128'(33'd1));
        check("R6 16 mux frame pol", 128'(frame_pol), 128'(1));

        // R6: 33-common order
        duty_sel = 2'b10; fast_clk = 1'b0;
        start_scan();
        clocks(31 * 17);
        check("R6 33 mux common 31", 128'(com_sel), 128'(33'd1 << 31));
        clocks(17);
        check("R6 33 mux icon common", 128'(com_sel), 128'(33'd1 << 32));
        clocks(17);
        check("R6 33 mux wraps to 0", 128'(com_sel), 128'(33'd1));
        check("R8 33 mux frame pol", 128'(frame_pol), 128'(1));

        // R9: icon-only mode whole frame
        icon_only = 1'b1; duty_sel = 2'b00;
        start_scan();
        clocks(575);
        check("R9 icon only late in frame", 128'(com_sel), 128'(33'd1 << 32));
        check("R9 pol before frame end", 128'(frame_pol), 128'(0));
        clocks(1);
        check("R9 icon only next frame", 128'(com_sel), 128'(33'd1 << 32));
        check("R9 pol at frame end", 128'(frame_pol), 128'(1));

        // R10: display off blanks outputs
        disp_on = 1'b0;
        clocks(1);
        check("R10 com off", 128'(com_sel), 128'(0));
        check("R10 seg off", 128'(seg_out), 128'(0));
        check("R10 pol off", 128'(frame_pol), 128'(0));
        disp_on = 1'b1;
        clocks(1);
        check("R10 restart in icon mode", 128'(com_sel), 128'(33'd1 << 32));
        icon_only = 1'b0;

        // Vector table: R2 R3 R4 R5 R6 R9 mapping probes
        for (int i = 0; i < NV; i++) begin
            logic [16:0] v;
            int probe, pos;
            v = VEC[i];
            duty_sel  = v[16:15];
            fast_clk  = v[14];
            scroll    = v[13:9];
            row_rev   = v[8];
            col_rev   = v[7];
            icon_only = v[6];
            probe     = int'(v[5:0]);
            start_scan();
            len = slot_of(v[14], v[16:15], v[6]);
            pos = v[6] ? 0 : probe;
            clocks(pos * len);
            check($sformatf("R2 R3 R6 R9 vector %0d common", i),
                  128'(com_sel), 128'(33'd1 << probe));
            check($sformatf("R2 R3 R4 R5 vector %0d segments", i),
                  128'(seg_out), 128'(exp_seg(probe, v[8], v[7], int'(v[13:9]))));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R12: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule